// File: doc/BRIEF.md
# Hardware Loop Instruction Buffer

This block sits between an instruction fetch unit that runs ahead on its own and the decoder. Fetched instruction words enter through a valid/ready write port and leave in order through a valid/ready read port. With no loop active the block is a plain 32-entry first-in first-out queue, and each read frees its slot.

A loop is declared on the setup port before its body is written. The setup gives the body length and the number of extra passes. The next word written is the loop's first entry, and the body's last entry lies that many words further on. The body is fetched and stored only once. When the read side reaches the last entry and passes remain, reading restarts at the first entry and the block's own counter for that loop drops by one. Entries read inside the outermost active loop stay held, so they can be replayed. The whole held span is freed together when the outermost loop finishes its last pass. Up to 16 loops can be declared and nested. An inner loop's pass count is reloaded each time it completes, so it runs its full count again on every pass of an enclosing loop. Nested bodies must begin at different entries and end at different entries.

Top module: `hlb_loop_buffer`

## Requirements
- R1: After reset `rd_valid` is 0, `wr_ready` is 1 and `lp_ovf` is 0.
- R2: With no loop declared, words are read in the order they were written. `rd_data` holds steady while `rd_valid` is 1 and `rd_ready` is 0.
- R3: `wr_ready` is 0 exactly when all 32 slots are occupied, counting both unread and held entries. A single read that frees a slot raises it again on the next cycle.
- R4: A loop declared with `lp_last` = L and `lp_rep` = N covers the next L+1 words written. The read side delivers that body N+1 times in a row and then continues with the word after the body. The body is written only once.
- R5: Nested loops run their own counts. When an inner loop completes, its count is reloaded, so every pass of the enclosing loop repeats the inner body N+1 times again.
- R6: Entries read while the outermost loop is active are not freed. They count toward occupancy until that loop's last read of its final entry, and then all of them become free on the next cycle.
- R7: A loop setup made while 16 loops are declared is ignored. `lp_ovf` is 1 for the one cycle after that request.
- R8: `flush` empties the buffer and discards every declared loop by the next cycle. After it, `rd_valid` is 0 and `wr_ready` is 1.
- R9: `rd_valid` is 1 exactly when at least one entry remains to be read on the current pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of entries and loops |
| wr_valid | input | 1 | Fetch side offers a word |
| wr_data | input | 16 | Instruction word from fetch |
| wr_ready | output | 1 | A free slot exists |
| rd_valid | output | 1 | A word is available to decode |
| rd_data | output | 16 | Instruction word to decode |
| rd_ready | input | 1 | Decode takes the word |
| lp_valid | input | 1 | Loop setup request |
| lp_last | input | 5 | Body length minus one |
| lp_rep | input | 16 | Extra passes after the first |
| lp_ovf | output | 1 | Setup rejected, stack full |

## Verification
A wrong pass counter or jump target shows at `rd_data` within one read of the body's last entry. The bench sees it as a repeated or skipped word in an otherwise known sequence. A wrong occupancy count, which includes releasing held entries too early or too late, shows as `wr_ready` holding the wrong level on the cycle after the read that should have changed it. Stack overflow and flush are each visible one cycle after the request, in `lp_ovf`, `rd_valid` and the read sequence that follows.

// File: rtl/hlb_pkg.sv
package hlb_pkg;
  // Decision taken for the entry read in the current cycle.
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,  // no read this cycle
    RD_STEP = 2'd1,  // advance to the next entry
    RD_JUMP = 2'd2,  // body end with passes left: back to body start
    RD_EXIT = 2'd3   // body end on last pass: leave the loop
  } rd_act_e;
endpackage

// File: rtl/hlb_store.sv
module hlb_store #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] cell_q [DEPTH];

  // Storage cells carry no reset; occupancy lives in the control logic.
  always_ff @(posedge clk) begin
    if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/hlb_loop_seq.sv
module hlb_loop_seq
  import hlb_pkg::*;
#(
  parameter int unsigned NEST  = 16,
  parameter int unsigned PTR_W = 5,
  parameter int unsigned REP_W = 16,
  localparam int unsigned SP_W   = $clog2(NEST + 1),
  localparam int unsigned IDX_W  = $clog2(NEST),
  localparam int unsigned SPAN_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push_req,
  input  logic [PTR_W-1:0]  push_head,
  input  logic [PTR_W-1:0]  push_tail,
  input  logic [SPAN_W-1:0] push_span,
  input  logic [REP_W-1:0]  push_rep,
  input  logic              rd_fire,
  input  logic [PTR_W-1:0]  rd_ptr,
  output rd_act_e           act,
  output logic [PTR_W-1:0]  jump_head,
  output logic [SPAN_W-1:0] jump_span,
  output logic              release_all,
  output logic [SPAN_W-1:0] release_span,
  output logic              freeable,
  output logic              push_reject,
  output logic [SP_W-1:0]   level
);
  // Frame storage, one slot per nesting level.
  logic [PTR_W-1:0]  head_q [NEST];
  logic [PTR_W-1:0]  tail_q [NEST];
  logic [SPAN_W-1:0] span_q [NEST];
  logic [REP_W-1:0]  rep_q  [NEST];
  logic [REP_W-1:0]  left_q [NEST];

  // sp: frames declared; nin: frames the read pointer is currently inside.
  logic [SP_W-1:0] sp_q, sp_d;
  logic [SP_W-1:0] nin_q, nin_d;

  logic              entering;
  logic              in_loop;
  logic [SP_W-1:0]   cur;
  logic [IDX_W-1:0]  cur_idx;
  logic [IDX_W-1:0]  nin_idx;
  logic              at_tail;
  logic              accept;
  logic [SP_W-1:0]   push_lvl;

  always_comb begin
    nin_idx  = IDX_W'(nin_q);
    entering = (nin_q < sp_q) && (rd_ptr == head_q[nin_idx]);
    in_loop  = entering || (nin_q != '0);
    cur      = entering ? nin_q : (nin_q - SP_W'(1));
    cur_idx  = IDX_W'(cur);
    at_tail  = in_loop && (rd_ptr == tail_q[cur_idx]);

    if (!rd_fire) begin
      act = RD_IDLE;
    end else if (at_tail && (left_q[cur_idx] != '0)) begin
      act = RD_JUMP;
    end else if (at_tail) begin
      act = RD_EXIT;
    end else begin
      act = RD_STEP;
    end

    release_all  = (act == RD_EXIT) && (cur == '0);
    release_span = span_q[0];
    jump_head    = head_q[cur_idx];
    jump_span    = span_q[cur_idx];
    freeable     = (nin_q == '0) && !entering;

    accept      = push_req && ((sp_q != SP_W'(NEST)) || release_all);
    push_reject = push_req && !accept;
    push_lvl    = release_all ? '0 : sp_q;
  end

  // Next-state for the stack depth and the entered-level count.
  always_comb begin
    sp_d  = sp_q;
    nin_d = nin_q;
    if (clear) begin
      sp_d  = '0;
      nin_d = '0;
    end else begin
      if (release_all) begin
        sp_d = '0;
      end
      if (accept) begin
        sp_d = push_lvl + SP_W'(1);
      end
      if (release_all) begin
        nin_d = '0;
      end else if (act == RD_EXIT) begin
        nin_d = cur;
      end else if (rd_fire && entering) begin
        nin_d = nin_q + SP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      nin_q <= '0;
    end else begin
      sp_q  <= sp_d;
      nin_q <= nin_d;
    end
  end

  // Frame contents: loaded on push, counter stepped on jump, reloaded on exit.
  always_ff @(posedge clk) begin
    for (int l = 0; l < NEST; l++) begin
      if (accept && !clear && (push_lvl == SP_W'(l))) begin
        head_q[l] <= push_head;
        tail_q[l] <= push_tail;
        span_q[l] <= push_span;
        rep_q[l]  <= push_rep;
        left_q[l] <= push_rep;
      end else if ((act == RD_JUMP) && (cur == SP_W'(l))) begin
        left_q[l] <= left_q[l] - REP_W'(1);
      end else if ((act == RD_EXIT) && (cur == SP_W'(l))) begin
        left_q[l] <= rep_q[l];
      end
    end
  end

  assign level = sp_q;
endmodule

// File: rtl/hlb_loop_buffer.sv
module hlb_loop_buffer
  import hlb_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned NEST   = 16,
  parameter int unsigned REP_W  = 16,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned SPAN_W = PTR_W + 1,
  localparam int unsigned SP_W   = $clog2(NEST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  input  logic              rd_ready,
  input  logic              lp_valid,
  input  logic [PTR_W-1:0]  lp_last,
  input  logic [REP_W-1:0]  lp_rep,
  output logic              lp_ovf
);
  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic [CNT_W-1:0] unread_q, unread_d;
  logic [CNT_W-1:0] occ_q, occ_d;
  logic             ovf_q, ovf_d;

  logic              wr_fire;
  logic              rd_fire;
  logic              push_req;
  logic [PTR_W-1:0]  body_tail;
  logic [SPAN_W-1:0] body_span;
  rd_act_e           act;
  logic [PTR_W-1:0]  jump_head;
  logic [SPAN_W-1:0] jump_span;
  logic              release_all;
  logic [SPAN_W-1:0] release_span;
  logic              freeable;
  logic              push_reject;
  logic [SP_W-1:0]   loop_level;

  // Ring increment that also works for a depth that is not a power of two.
  function automatic logic [PTR_W-1:0] ring_add(input logic [PTR_W-1:0] base,
                                                input logic [SPAN_W-1:0] inc);
    logic [SPAN_W:0] sum;
    sum = {1'b0, {1'b0, base} + inc};
    if (sum >= (SPAN_W + 1)'(DEPTH)) begin
      sum = sum - (SPAN_W + 1)'(DEPTH);
    end
    return PTR_W'(sum);
  endfunction

  always_comb begin
    wr_fire   = wr_valid && wr_ready && !flush;
    rd_fire   = rd_valid && rd_ready && !flush;
    push_req  = lp_valid && !flush;
    body_span = {1'b0, lp_last} + SPAN_W'(1);
    body_tail = ring_add(wptr_q, {1'b0, lp_last});
  end

  hlb_store #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wptr_q),
    .wdata (wr_data),
    .raddr (rptr_q),
    .rdata (rd_data)
  );

  hlb_loop_seq #(
    .NEST  (NEST),
    .PTR_W (PTR_W),
    .REP_W (REP_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (flush),
    .push_req     (push_req),
    .push_head    (wptr_q),
    .push_tail    (body_tail),
    .push_span    (body_span),
    .push_rep     (lp_rep),
    .rd_fire      (rd_fire),
    .rd_ptr       (rptr_q),
    .act          (act),
    .jump_head    (jump_head),
    .jump_span    (jump_span),
    .release_all  (release_all),
    .release_span (release_span),
    .freeable     (freeable),
    .push_reject  (push_reject),
    .level        (loop_level)
  );

  // Next-state for pointers and counters.
  always_comb begin
    wptr_d   = wptr_q;
    rptr_d   = rptr_q;
    unread_d = unread_q;
    occ_d    = occ_q;
    ovf_d    = 1'b0;
    if (flush) begin
      wptr_d   = '0;
      rptr_d   = '0;
      unread_d = '0;
      occ_d    = '0;
    end else begin
      ovf_d = push_reject;
      if (wr_fire) begin
        wptr_d = ring_add(wptr_q, SPAN_W'(1));
      end
      unique case (act)
        RD_JUMP: rptr_d = jump_head;
        RD_STEP,
        RD_EXIT: rptr_d = ring_add(rptr_q, SPAN_W'(1));
        default: rptr_d = rptr_q;
      endcase
      unread_d = unread_q + CNT_W'(wr_fire) - CNT_W'(rd_fire);
      if (act == RD_JUMP) begin
        unread_d = unread_d + CNT_W'(jump_span);
      end
      occ_d = occ_q + CNT_W'(wr_fire) - CNT_W'(rd_fire && freeable);
      if (release_all) begin
        occ_d = occ_d - CNT_W'(release_span);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      unread_q <= '0;
      occ_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wptr_q   <= wptr_d;
      rptr_q   <= rptr_d;
      unread_q <= unread_d;
      occ_q    <= occ_d;
      ovf_q    <= ovf_d;
    end
  end

  assign rd_valid = (unread_q != '0);
  assign wr_ready = (occ_q != CNT_W'(DEPTH));
  assign lp_ovf   = ovf_q;
endmodule

// File: rtl/hlb_checker.sv
module hlb_checker #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned NEST   = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned SP_W  = $clog2(NEST + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lp_valid,
  input logic              lp_ovf,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [WORD_W-1:0] rd_data,
  input logic [CNT_W-1:0]  unread,
  input logic [CNT_W-1:0]  occ,
  input logic [SP_W-1:0]   level
);
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !flush |=> rd_valid && $stable(rd_data)); // R2

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready && !(rd_valid && rd_ready) && !flush |=> !wr_ready); // R3

  AST_UNREAD_WITHIN_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    unread <= occ); // R6

  AST_OVF_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    lp_ovf |-> $past(lp_valid) && ($past(level) == SP_W'(NEST))); // R7

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= SP_W'(NEST)); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_valid && wr_ready); // R8
endmodule

bind hlb_loop_buffer hlb_checker #(
  .WORD_W (WORD_W),
  .DEPTH  (DEPTH),
  .NEST   (NEST)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .lp_valid (lp_valid),
  .lp_ovf   (lp_ovf),
  .wr_ready (wr_ready),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .unread   (unread_q),
  .occ      (occ_q),
  .level    (loop_level)
);

// File: tb/hlb_loop_buffer_test.sv
module hlb_loop_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // Bit 16 set: write the low 16 bits; clear: read and expect them.
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 16'h1111}, {1'b1, 16'h2222}, {1'b0, 16'h1111}, {1'b1, 16'h3333},
    {1'b1, 16'h4444}, {1'b0, 16'h2222}, {1'b0, 16'h3333}, {1'b1, 16'h5555},
    {1'b0, 16'h4444}, {1'b0, 16'h5555}
  };

  logic        clk;
  logic        rst_n;
  logic        flush;
  logic        wr_valid;
  logic [15:0] wr_data;
  logic        wr_ready;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        rd_ready;
  logic        lp_valid;
  logic [4:0]  lp_last;
  logic [15:0] lp_rep;
  logic        lp_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hlb_loop_buffer uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .lp_valid(lp_valid), .lp_last(lp_last), .lp_rep(lp_rep), .lp_ovf(lp_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [15:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] exp, input string req);
    chk(rd_valid && (rd_data == exp), req, {rd_valid, rd_data}, {1'b1, exp});
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic setup(input logic [4:0] last, input logic [15:0] rep);
    lp_valid = 1'b1;
    lp_last  = last;
    lp_rep   = rep;
    @(negedge clk);
    lp_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_up();
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; wr_valid = 1'b0; wr_data = '0;
    rd_ready = 1'b0; lp_valid = 1'b0; lp_last = '0; lp_rep = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(!rd_valid, "R1 rd_valid", rd_valid, 0);
    chk(wr_ready, "R1 wr_ready", wr_ready, 1);
    chk(!lp_ovf, "R1 lp_ovf", lp_ovf, 0);

    // R2: plain queue order from the vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][16]) wr(VEC[i][15:0]);
      else rd(VEC[i][15:0], "R2 order");
    end
    // R9: nothing left to read
    chk(!rd_valid, "R9 empty", rd_valid, 0);

    // R4: body of three, two extra passes, then the next word
    do_flush();
    setup(5'd2, 16'd2);
    wr(16'hA000); wr(16'hA001); wr(16'hA002); wr(16'hA003);
    for (int p = 0; p < 3; p++) begin
      rd(16'hA000, "R4 pass"); rd(16'hA001, "R4 pass"); rd(16'hA002, "R4 pass");
    end
    rd(16'hA003, "R4 after body");
    chk(!rd_valid, "R9 after loop", rd_valid, 0);

    // R5: outer body X Y Z W once repeated, inner body Y Z once repeated
    do_flush();
    setup(5'd3, 16'd1);
    wr(16'hB0);
    setup(5'd1, 16'd1);
    wr(16'hB1); wr(16'hB2); wr(16'hB3); wr(16'hB4);
    for (int p = 0; p < 2; p++) begin
      rd(16'hB0, "R5 outer");
      rd(16'hB1, "R5 inner"); rd(16'hB2, "R5 inner");
      rd(16'hB1, "R5 inner"); rd(16'hB2, "R5 inner");
      rd(16'hB3, "R5 outer");
    end
    rd(16'hB4, "R5 tail");

    // R3: 32 unread entries fill the buffer; one read frees a slot
    do_flush();
    for (int i = 0; i < 32; i++) wr(16'(16'hC000 + i));
    chk(!wr_ready, "R3 full", wr_ready, 0);
    rd(16'hC000, "R3 first");
    chk(wr_ready, "R3 slot freed", wr_ready, 1);

    // R6: held body counts toward occupancy until the loop ends
    do_flush();
    setup(5'd3, 16'd1);
    for (int i = 0; i < 4; i++) wr(16'(16'hD000 + i));
    for (int i = 0; i < 4; i++) rd(16'(16'hD000 + i), "R6 first pass");
    begin
      int refused = 0;
      for (int i = 0; i < 28; i++) begin
        if (!wr_ready) refused++;
        wr(16'(16'hE000 + i));
      end
      chk(refused == 0, "R6 28 free slots", refused, 0);
    end
    chk(!wr_ready, "R6 held entries occupy", wr_ready, 0);
    for (int i = 0; i < 4; i++) rd(16'(16'hD000 + i), "R6 replay");
    chk(wr_ready, "R6 released", wr_ready, 1);
    rd(16'hE000, "R6 after body");

    // R7: seventeenth setup is refused
    do_flush();
    for (int i = 0; i < 16; i++) begin
      setup(5'd0, 16'd0);
      wr(16'(16'hF000 + i));
    end
    chk(!lp_ovf, "R7 no overflow at 16", lp_ovf, 0);
    setup(5'd0, 16'd3);
    chk(lp_ovf, "R7 overflow flag", lp_ovf, 1);
    wr(16'hFFEE);
    chk(!lp_ovf, "R7 flag one cycle", lp_ovf, 0);
    for (int i = 0; i < 16; i++) rd(16'(16'hF000 + i), "R7 stored");
    rd(16'hFFEE, "R7 refused loop");
    chk(!rd_valid, "R7 refused loop not replayed", rd_valid, 0);

    // R8: flush drops entries and loops
    do_flush();
    setup(5'd0, 16'd5);
    wr(16'h0101); wr(16'h0202); wr(16'h0303);
    do_flush();
    chk(!rd_valid, "R8 rd_valid", rd_valid, 0);
    chk(wr_ready, "R8 wr_ready", wr_ready, 1);
    wr(16'hBEEF);
    rd(16'hBEEF, "R8 after flush");
    chk(!rd_valid, "R8 loop discarded", rd_valid, 0);

    done = 1;
    finish_up();
  end
endmodule